// File: doc/BRIEF.md
# Parallel ATA PIO Host Engine

This block is the host side of a parallel ATA port for programmed I/O. One start request runs one 16-bit bus cycle to a single device register. The cycle can be a read or a write. Software sets the target address, the word to send, the direction and the timing counts. It then pulses start and waits for the completion flag. After a read, software takes the received word from the receive register.

Two timing sets are held side by side. Cycles to the data port (address 0) use the data-cycle set: a width register plus a packed word that carries setup, recovery and hold. Every other address uses the register-cycle set, which is a packed word holding width and recovery. Setup and write hold always come from the data-cycle word. All counts are in system clocks and are used exactly as given. The device can stretch the strobe through the ready line when that feature is enabled. A separate control input drives the bus reset line for as long as it is held.

Top module: `pata_pio_host`

## Requirements
- R1: After reset, both chip-selects are high (`ata_cs_n` = 2'b11), both strobes are high, `ata_dd_oe` is 0, `busy` is 0, `done_stat` is 0 and `irq` is 0.
- R2: While a cycle runs, `ata_cs_n` = 2'b10 when address bit 3 is 0 and 2'b01 when it is 1, and `ata_da` equals address bits 2:0. Both lines stay constant from start to finish. When idle, `ata_cs_n` = 2'b11.
- R3: Counting the start-accepting edge as edge 0, the strobe falls after edge S and stays low for max(W,1) clocks. Recovery then lasts max(R,H,1) clocks, and `busy` falls after edge S+max(W,1)+max(R,H,1).
- R4: Address 0 uses width = `tim_data_width` and recovery = `tim_data[11:4]`. Any other address uses width = `tim_reg[15:8]` and recovery = `tim_reg[7:0]`. For all addresses, setup S = `tim_data[3:0]` and hold H = `tim_data[15:12]`.
- R5: `cfg_write` = 1 pulses only `ata_diow_n`. It drives `cfg_tx_word` with `ata_dd_oe` = 1 from edge 0 until H clocks after the strobe rises. `cfg_write` = 0 pulses only `ata_dior_n` and never asserts `ata_dd_oe`.
- R6: On a read, `rx_word` takes the value of `ata_dd_in` present at the edge where the read strobe rises.
- R7: `done_stat` is set on the edge where `busy` falls. A 1 on `stat_clear` clears it, but a set on the same edge takes priority over the clear.
- R8: `irq` is `done_stat` AND `irq_mask`.
- R9: When `cfg_iordy_en` = 1 and `ata_iordy` is low (after a two-stage synchroniser), the strobe-width count is held. When `cfg_iordy_en` = 0, `ata_iordy` has no effect.
- R10: A start that arrives while `busy` is 1 is ignored and does not queue a second cycle.
- R11: `ata_reset_n` is low exactly while `cfg_dev_reset` is 1, whether or not a cycle is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_addr | input | 4 | Device register address (bit 3 selects the chip-select) |
| cfg_write | input | 1 | 1 = write toward the device, 0 = read |
| cfg_tx_word | input | 16 | Word to send on a write |
| cfg_start | input | 1 | Launch one cycle (accepted only when idle) |
| cfg_dev_reset | input | 1 | Holds the bus reset line active |
| cfg_iordy_en | input | 1 | Allow the device to stretch the strobe |
| tim_reg | input | 16 | Register-cycle timing: width [15:8], recovery [7:0] |
| tim_data | input | 16 | Data-cycle timing: hold [15:12], recovery [11:4], setup [3:0] |
| tim_data_width | input | 8 | Data-cycle strobe width |
| irq_mask | input | 1 | Lets the completion flag reach `irq` |
| stat_clear | input | 1 | Write-one-to-clear for the completion flag |
| rx_word | output | 16 | Word captured by the last read |
| busy | output | 1 | A cycle is in progress |
| done_stat | output | 1 | Completion flag |
| irq | output | 1 | Masked interrupt |
| ata_cs_n | output | 2 | Active-low chip-selects |
| ata_da | output | 3 | Register address lines |
| ata_dior_n | output | 1 | Read strobe, active low |
| ata_diow_n | output | 1 | Write strobe, active low |
| ata_reset_n | output | 1 | Device reset, active low |
| ata_dd_out | output | 16 | Data bus outgoing value |
| ata_dd_oe | output | 1 | Data bus drive enable |
| ata_dd_in | input | 16 | Data bus incoming value |
| ata_iordy | input | 1 | Device ready (asynchronous) |

## Verification
An off-by-one in a phase counter moves a strobe edge or the fall of `busy` by one clock within the same transfer. The bench sweeps setup, width, recovery and hold over small values, so such an error shows on the first affected combination. A wrong timing-set choice or a bad latched address shows as a wrong strobe length or wrong select lines during the very next cycle to the other address class. A sequencer stuck in one phase leaves `busy` high, and the bench reports this within a few hundred clocks. A misplaced capture edge changes `rx_word`, because the bench alters `ata_dd_in` on every clock.

// File: rtl/pata_pio_pkg.sv
package pata_pio_pkg;

    localparam int CNT_W  = 8;
    localparam int NIB_W  = 4;
    localparam int ADDR_W = 4;
    localparam int TIM_W  = 16;

    typedef logic [CNT_W-1:0] cnt_t;

    localparam cnt_t CNT_ONE = cnt_t'(1);
    localparam logic [ADDR_W-1:0] DATA_PORT_ADDR = '0;

    typedef struct packed {
        cnt_t setup;
        cnt_t width;
        cnt_t recov;
        cnt_t hold;
    } pio_timing_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_RECOV
    } pio_phase_t;

    function automatic cnt_t at_least_one(input cnt_t v);
        return (v == '0) ? CNT_ONE : v;
    endfunction

    function automatic cnt_t recov_span(input cnt_t r, input cnt_t h);
        cnt_t m;
        m = (r > h) ? r : h;
        return at_least_one(m);
    endfunction

    function automatic logic [1:0] cs_decode(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1] ? 2'b01 : 2'b10;
    endfunction

endpackage

// File: rtl/pata_timing_sel.sv
module pata_timing_sel
    import pata_pio_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [TIM_W-1:0]  reg_word,
    input  logic [TIM_W-1:0]  data_word,
    input  cnt_t              data_width,
    output pio_timing_t       tim
);
    always_comb begin
        tim.setup = cnt_t'(data_word[NIB_W-1:0]);
        tim.hold  = cnt_t'(data_word[TIM_W-1:TIM_W-NIB_W]);
        if (addr == DATA_PORT_ADDR) begin
            tim.width = data_width;
            tim.recov = data_word[NIB_W+CNT_W-1:NIB_W];
        end else begin
            tim.width = reg_word[TIM_W-1:CNT_W];
            tim.recov = reg_word[CNT_W-1:0];
        end
    end
endmodule

// File: rtl/pata_iordy_sync.sv
module pata_iordy_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out
);
    generate
        if (STAGES > 1) begin : g_chain
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[STAGES-2:0], async_in};
            end
            assign sync_out = chain[STAGES-1];
        end else begin : g_single
            logic q;
            always_ff @(posedge clk) begin
                if (rst) q <= 1'b1;
                else     q <= async_in;
            end
            assign sync_out = q;
        end
    endgenerate
endmodule

// File: rtl/pata_irq_stat.sv
module pata_irq_stat (
    input  logic clk,
    input  logic rst,
    input  logic set_evt,
    input  logic clr_req,
    input  logic mask,
    output logic stat,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst)          stat <= 1'b0;
        else if (set_evt) stat <= 1'b1;
        else if (clr_req) stat <= 1'b0;
    end
    assign irq = stat & mask;
endmodule

// File: rtl/pata_pio_seq.sv
module pata_pio_seq
    import pata_pio_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr,
    input  logic              write,
    input  logic [DATA_W-1:0] tx_word,
    input  pio_timing_t       tim,
    input  logic              stall,
    input  logic [DATA_W-1:0] dd_in,
    output logic [1:0]        cs_n,
    output logic [2:0]        da,
    output logic              dior_n,
    output logic              diow_n,
    output logic [DATA_W-1:0] dd_out,
    output logic              dd_oe,
    output logic [DATA_W-1:0] rx_word,
    output logic              busy,
    output logic              finish
);
    pio_phase_t        phase;
    cnt_t              cnt;
    cnt_t              hold_cnt;
    logic [ADDR_W-1:0] lat_addr;
    logic              lat_wr;
    logic [DATA_W-1:0] lat_tx;
    pio_timing_t       lat_tim;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            cnt      <= '0;
            hold_cnt <= '0;
            lat_addr <= '0;
            lat_wr   <= 1'b0;
            lat_tx   <= '0;
            lat_tim  <= '0;
            rx_word  <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        lat_addr <= addr;
                        lat_wr   <= write;
                        lat_tx   <= tx_word;
                        lat_tim  <= tim;
                        if (tim.setup != '0) begin
                            phase <= PH_SETUP;
                            cnt   <= tim.setup - CNT_ONE;
                        end else begin
                            phase <= PH_STROBE;
                            cnt   <= at_least_one(tim.width) - CNT_ONE;
                        end
                    end
                end
                PH_SETUP: begin
                    if (cnt == '0) begin
                        phase <= PH_STROBE;
                        cnt   <= at_least_one(lat_tim.width) - CNT_ONE;
                    end else begin
                        cnt <= cnt - CNT_ONE;
                    end
                end
                PH_STROBE: begin
                    if (!stall) begin
                        if (cnt == '0) begin
                            phase    <= PH_RECOV;
                            cnt      <= recov_span(lat_tim.recov, lat_tim.hold) - CNT_ONE;
                            hold_cnt <= lat_tim.hold;
                            if (!lat_wr) rx_word <= dd_in;
                        end else begin
                            cnt <= cnt - CNT_ONE;
                        end
                    end
                end
                PH_RECOV: begin
                    if (hold_cnt != '0) hold_cnt <= hold_cnt - CNT_ONE;
                    if (cnt == '0) phase <= PH_IDLE;
                    else           cnt   <= cnt - CNT_ONE;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        busy   = (phase != PH_IDLE);
        finish = (phase == PH_RECOV) && (cnt == '0);
        cs_n   = busy ? cs_decode(lat_addr) : 2'b11;
        da     = busy ? lat_addr[2:0] : 3'b000;
        dior_n = !((phase == PH_STROBE) && !lat_wr);
        diow_n = !((phase == PH_STROBE) &&  lat_wr);
        dd_out = lat_tx;
        dd_oe  = lat_wr && ((phase == PH_SETUP) || (phase == PH_STROBE) ||
                            ((phase == PH_RECOV) && (hold_cnt != '0)));
    end
endmodule

// File: rtl/pata_pio_host.sv
module pata_pio_host
    import pata_pio_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        cfg_addr,
    input  logic              cfg_write,
    input  logic [DATA_W-1:0] cfg_tx_word,
    input  logic              cfg_start,
    input  logic              cfg_dev_reset,
    input  logic              cfg_iordy_en,
    input  logic [15:0]       tim_reg,
    input  logic [15:0]       tim_data,
    input  logic [7:0]        tim_data_width,
    input  logic              irq_mask,
    input  logic              stat_clear,
    output logic [DATA_W-1:0] rx_word,
    output logic              busy,
    output logic              done_stat,
    output logic              irq,
    output logic [1:0]        ata_cs_n,
    output logic [2:0]        ata_da,
    output logic              ata_dior_n,
    output logic              ata_diow_n,
    output logic              ata_reset_n,
    output logic [DATA_W-1:0] ata_dd_out,
    output logic              ata_dd_oe,
    input  logic [DATA_W-1:0] ata_dd_in,
    input  logic              ata_iordy
);
    pio_timing_t sel_tim;
    logic        iordy_s;
    logic        stall;
    logic        finish;

    pata_timing_sel u_tsel (
        .addr       (cfg_addr),
        .reg_word   (tim_reg),
        .data_word  (tim_data),
        .data_width (tim_data_width),
        .tim        (sel_tim)
    );

    pata_iordy_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (ata_iordy),
        .sync_out (iordy_s)
    );

    assign stall = cfg_iordy_en & ~iordy_s;

    pata_pio_seq #(.DATA_W(DATA_W)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (cfg_start),
        .addr    (cfg_addr),
        .write   (cfg_write),
        .tx_word (cfg_tx_word),
        .tim     (sel_tim),
        .stall   (stall),
        .dd_in   (ata_dd_in),
        .cs_n    (ata_cs_n),
        .da      (ata_da),
        .dior_n  (ata_dior_n),
        .diow_n  (ata_diow_n),
        .dd_out  (ata_dd_out),
        .dd_oe   (ata_dd_oe),
        .rx_word (rx_word),
        .busy    (busy),
        .finish  (finish)
    );

    pata_irq_stat u_stat (
        .clk     (clk),
        .rst     (rst),
        .set_evt (finish),
        .clr_req (stat_clear),
        .mask    (irq_mask),
        .stat    (done_stat),
        .irq     (irq)
    );

    assign ata_reset_n = ~cfg_dev_reset;
endmodule

// File: rtl/pata_pio_host_chk.sv
module pata_pio_host_chk (
    input logic       clk,
    input logic       rst,
    input logic       cfg_start,
    input logic       busy,
    input logic       done_stat,
    input logic       irq,
    input logic [1:0] ata_cs_n,
    input logic [2:0] ata_da,
    input logic       ata_dior_n,
    input logic       ata_diow_n,
    input logic       ata_dd_oe
);
    // R5
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(!ata_dior_n && !ata_diow_n));

    // R2
    strobe_cs_chk: assert property (@(posedge clk) disable iff (rst)
        (!ata_dior_n || !ata_diow_n) |-> (ata_cs_n != 2'b11));

    // R2
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ($stable(ata_da) && $stable(ata_cs_n)));

    // R7
    done_end_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done_stat) |-> $fell(busy));

    // R10
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(cfg_start));

    // R5
    read_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
        !ata_dior_n |-> !ata_dd_oe);

    // R8
    irq_src_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> done_stat);
endmodule

bind pata_pio_host pata_pio_host_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_start  (cfg_start),
    .busy       (busy),
    .done_stat  (done_stat),
    .irq        (irq),
    .ata_cs_n   (ata_cs_n),
    .ata_da     (ata_da),
    .ata_dior_n (ata_dior_n),
    .ata_diow_n (ata_diow_n),
    .ata_dd_oe  (ata_dd_oe)
);

// File: tb/pata_pio_host_test.sv
module pata_pio_host_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  cfg_addr = '0;
    logic        cfg_write = 1'b0;
    logic [15:0] cfg_tx_word = '0;
    logic        cfg_start = 1'b0;
    logic        cfg_dev_reset = 1'b0;
    logic        cfg_iordy_en = 1'b0;
    logic [15:0] tim_reg = '0;
    logic [15:0] tim_data = '0;
    logic [7:0]  tim_data_width = '0;
    logic        irq_mask = 1'b0;
    logic        stat_clear = 1'b0;
    logic [15:0] rx_word;
    logic        busy, done_stat, irq;
    logic [1:0]  ata_cs_n;
    logic [2:0]  ata_da;
    logic        ata_dior_n, ata_diow_n, ata_reset_n;
    logic [15:0] ata_dd_out;
    logic        ata_dd_oe;
    logic [15:0] ata_dd_in = '0;
    logic        ata_iordy = 1'b1;

    int checks = 0;
    int errors = 0;
    bit ended = 1'b0;

    always #4 clk = ~clk;

    pata_pio_host uut (
        .clk(clk), .rst(rst), .cfg_addr(cfg_addr), .cfg_write(cfg_write),
        .cfg_tx_word(cfg_tx_word), .cfg_start(cfg_start), .cfg_dev_reset(cfg_dev_reset),
        .cfg_iordy_en(cfg_iordy_en), .tim_reg(tim_reg), .tim_data(tim_data),
        .tim_data_width(tim_data_width), .irq_mask(irq_mask), .stat_clear(stat_clear),
        .rx_word(rx_word), .busy(busy), .done_stat(done_stat), .irq(irq),
        .ata_cs_n(ata_cs_n), .ata_da(ata_da), .ata_dior_n(ata_dior_n),
        .ata_diow_n(ata_diow_n), .ata_reset_n(ata_reset_n), .ata_dd_out(ata_dd_out),
        .ata_dd_oe(ata_dd_oe), .ata_dd_in(ata_dd_in), .ata_iordy(ata_iordy)
    );

    task automatic check_eq(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_sim();
        if (!ended) begin
            ended = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    function automatic int max1(input int v);
        return (v < 1) ? 1 : v;
    endfunction

    // Runs one transfer and checks timing, strobes, selects, data and flag.
    task automatic run_cycle(input logic [3:0] addr, input logic wr, input logic [15:0] tx,
                             output int strobe_len);
        int s, w1, rec, h, r, n_end, n;
        int first_lo, last_lo, lo_cnt, wrong, oe_cnt, oe_bad, cs_bad;
        logic [1:0] exp_cs;
        s  = int'(tim_data[3:0]);
        h  = int'(tim_data[15:12]);
        if (addr == 4'd0) begin // R4 data-port set
            w1 = max1(int'(tim_data_width));
            r  = int'(tim_data[11:4]);
        end else begin          // R4 register set
            w1 = max1(int'(tim_reg[15:8]));
            r  = int'(tim_reg[7:0]);
        end
        rec   = max1((r > h) ? r : h);
        n_end = s + w1 + rec + 1;
        exp_cs = addr[3] ? 2'b01 : 2'b10;
        first_lo = -1; last_lo = -1; lo_cnt = 0; wrong = 0;
        oe_cnt = 0; oe_bad = 0; cs_bad = 0; n = 0;
        @(negedge clk);
        cfg_addr = addr; cfg_write = wr; cfg_tx_word = tx; cfg_start = 1'b1;
        ata_dd_in = 16'hA500;
        while (n < 400) begin
            @(negedge clk);
            n++;
            cfg_start = 1'b0;
            if (!(wr ? ata_diow_n : ata_dior_n)) begin
                lo_cnt++;
                if (first_lo < 0) first_lo = n;
                last_lo = n;
            end
            if (!(wr ? ata_dior_n : ata_diow_n)) wrong++;
            if (ata_dd_oe) begin
                oe_cnt++;
                if (ata_dd_out !== tx) oe_bad++;
            end
            if (!busy) break;
            if (ata_cs_n !== exp_cs || ata_da !== addr[2:0]) cs_bad++;
            ata_dd_in = {8'hA5, 8'(n)};
        end
        strobe_len = lo_cnt;
        check_eq("R3", "strobe fall sample", first_lo, s + 1);
        check_eq("R4", "strobe width", lo_cnt, w1);
        check_eq("R3", "strobe rise sample", last_lo, s + w1);
        check_eq("R3", "busy end sample", n, n_end);
        check_eq("R5", "opposite strobe pulses", wrong, 0);
        check_eq("R5", "drive length", oe_cnt, wr ? (s + w1 + h) : 0);
        check_eq("R5", "driven word mismatches", oe_bad, 0);
        check_eq("R2", "select/address mismatches", cs_bad, 0);
        check_eq("R2", "idle chip-selects", ata_cs_n, 2'b11);
        check_eq("R7", "done flag at end", done_stat, 1);
        if (!wr) check_eq("R6", "captured word", rx_word, {8'hA5, 8'(s + w1)});
    endtask

    task automatic clear_flag();
        @(negedge clk); stat_clear = 1'b1;
        @(negedge clk); stat_clear = 1'b0;
        check_eq("R7", "flag after clear", done_stat, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_sim();
    end

    initial begin
        int sl;
        int sv[3] = '{0, 1, 3};
        int wv[3] = '{0, 1, 3};
        int rv[3] = '{0, 2, 5};
        int hv[3] = '{0, 1, 4};
        logic [3:0] av[3] = '{4'd0, 4'd5, 4'd9};
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check_eq("R1", "cs idle", ata_cs_n, 2'b11);
        check_eq("R1", "strobes idle", {ata_dior_n, ata_diow_n}, 2'b11);
        check_eq("R1", "busy/oe/flag/irq", {busy, ata_dd_oe, done_stat, irq}, 0);

        // Sweep of timing values, addresses and directions (R3 R4 R5 R6 R2)
        for (int a = 0; a < 3; a++)
            for (int d = 0; d < 2; d++)
                for (int i = 0; i < 3; i++)
                    for (int j = 0; j < 3; j++)
                        for (int k = 0; k < 3; k++)
                            for (int m = 0; m < 3; m++) begin
                                tim_data = {4'(hv[m]), 8'(rv[k]), 4'(sv[i])};
                                tim_data_width = 8'(wv[j]);
                                tim_reg = {8'(wv[j] + 2), 8'(rv[k] + 1)};
                                run_cycle(av[a], d[0], 16'h3C00 + 16'(i * 27 + j * 9 + k * 3 + m), sl);
                                clear_flag();
                            end

        // R8 interrupt masking
        tim_data = 16'h0011; tim_data_width = 8'd2;
        irq_mask = 1'b0;
        run_cycle(4'd0, 1'b1, 16'h1234, sl);
        check_eq("R8", "irq masked", irq, 0);
        @(negedge clk); irq_mask = 1'b1;
        @(negedge clk);
        check_eq("R8", "irq unmasked", irq, 1);
        clear_flag();
        check_eq("R8", "irq after clear", irq, 0);
        irq_mask = 1'b0;

        // R7 set wins over a simultaneous clear
        stat_clear = 1'b1;
        run_cycle(4'd3, 1'b0, 16'h0, sl);
        @(negedge clk);
        check_eq("R7", "cleared one clock later", done_stat, 0);
        stat_clear = 1'b0;

        // R10 start while busy ignored
        tim_data = 16'h0020; tim_data_width = 8'd3;
        @(negedge clk);
        cfg_addr = 4'd0; cfg_write = 1'b0; cfg_start = 1'b1;
        sl = 0;
        for (int n = 0; n < 30; n++) begin
            @(negedge clk);
            if (n == 3) cfg_start = 1'b0;
            if (!ata_dior_n) sl++;
        end
        check_eq("R10", "strobe clocks for held start", sl, 3);
        check_eq("R10", "busy after single cycle", busy, 0);
        clear_flag();

        // R9 ready stretching enabled
        tim_data = 16'h0010; tim_data_width = 8'd2;
        cfg_iordy_en = 1'b1; ata_iordy = 1'b0;
        repeat (4) @(negedge clk);
        cfg_addr = 4'd0; cfg_write = 1'b0; cfg_start = 1'b1;
        for (int n = 0; n < 10; n++) begin
            @(negedge clk);
            cfg_start = 1'b0;
        end
        check_eq("R9", "strobe held while not ready", ata_dior_n, 0);
        ata_iordy = 1'b1;
        for (int n = 0; n < 20; n++) begin
            @(negedge clk);
            if (!busy) break;
        end
        check_eq("R9", "cycle ends after ready", busy, 0);
        clear_flag();

        // R9 ready ignored when disabled
        cfg_iordy_en = 1'b0; ata_iordy = 1'b0;
        repeat (3) @(negedge clk);
        run_cycle(4'd0, 1'b0, 16'h0, sl);
        check_eq("R9", "width with ready disabled", sl, 2);
        clear_flag();
        ata_iordy = 1'b1;

        // R11 device reset line
        @(negedge clk); cfg_dev_reset = 1'b1;
        #1 check_eq("R11", "reset line asserted", ata_reset_n, 0);
        run_cycle(4'd1, 1'b1, 16'hBEEF, sl);
        check_eq("R11", "reset line held through cycle", ata_reset_n, 0);
        clear_flag();
        cfg_dev_reset = 1'b0;
        #1 check_eq("R11", "reset line released", ata_reset_n, 1);

        finish_sim();
    end
endmodule